// File: doc/BRIEF.md
# Two-Key Watchdog Timer

This block is a watchdog timer. Software keeps it quiet by writing a two-byte key to its arm register. Once enabled, a counter advances on every clock. If that counter reaches the selected timeout before the key is completed, the block sends a one-cycle reset request to the reset logic of the chip.

The key has two bytes that must come in order. An arming write of 0x55 opens the sequence, and a closing write of 0xAA then clears the timer. Any other byte written to the arm register while the block is enabled counts as a software fault and requests a reset at once. A two-bit select input chooses one of four timeout lengths. Each length is a power of two clock cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: While `enable` is low, `reset_req` stays low, writes have no effect, and the counter and key state are held clear. After `enable` rises, a timeout needs a full period.
- R2: `period_sel` chooses the period P: 0 gives 2^10, 1 gives 2^12, 2 gives 2^14 and 3 gives 2^16 cycles. With no service, `reset_req` is high in the cycle after the P-th rising edge since the timer was last cleared.
- R3: A write of 0xAA while armed is a completion and clears the timer at that edge. Arming means a 0x55 write since the last clear. Repeated 0x55 writes and idle cycles between the two keys are allowed.
- R4: A write of 0xAA while not armed is ignored, so the timeout stays where it was.
- R5: Writing any byte other than 0x55 or 0xAA while enabled makes `reset_req` high in the next cycle.
- R6: `reset_req` is a single-cycle pulse. When it fires, the counter and the key state are cleared, so the next request comes a full period later and a lone 0xAA written after it does not count.
- R7: If a completion lands on the same edge as the expiry, the completion wins and no request is made.
- R8: The timer expires when its count is at or above the selected limit. Lowering `period_sel` below the count already reached therefore requests a reset at the next edge.
- R9: The synchronous active-low reset `rst_n` clears the counter, the key state and `reset_req`, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Watchdog active when high |
| period_sel | input | 2 | Timeout selection, 2^(10+2*sel) cycles |
| wr_en | input | 1 | Write strobe for the arm register |
| wr_data | input | 8 | Byte written to the arm register |
| reset_req | output | 1 | One-cycle reset request |

## Verification
A wrong count shows up as a reset pulse on the wrong edge. The bench therefore samples `reset_req` on the edge just before the expected expiry and on the expiry edge itself, so an error of one cycle is caught. A key state that stays armed when it should have cleared lets a lone 0xAA move the next pulse a full period later, and that shift is visible within one timeout. A decode that misses a bad byte appears as a missing pulse one cycle after the write.

// File: rtl/wdg_pkg.sv
// Package: wdg_pkg
// Shared key values and key-state encoding for the two-key watchdog.
// Assumes byte-wide writes to the arm register.
package wdg_pkg;
    localparam logic [7:0] KEY_OPEN  = 8'h55;
    localparam logic [7:0] KEY_CLOSE = 8'hAA;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;
endpackage

// File: rtl/wdg_key_seq.sv
// Module: wdg_key_seq
// Decodes writes to the arm register. It tracks whether the opening key has
// been seen, flags a completed key pair and flags an illegal byte.
// Assumes: clear_i is the registered-fire condition of the same cycle.
module wdg_key_seq
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       clear_i,
    output logic       restart_o,
    output logic       bad_key_o
);
    key_state_e state_q;
    logic       wr_act;

    // Purpose: qualify writes with enable.
    always_comb begin
        wr_act    = enable_i && wr_en_i;
        restart_o = wr_act && (wr_data_i == KEY_CLOSE) && (state_q == KEY_ARMED);
        bad_key_o = wr_act && (wr_data_i != KEY_CLOSE) && (wr_data_i != KEY_OPEN);
    end

    // Purpose: advance the key state on qualified writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i || clear_i) begin
            state_q <= KEY_IDLE;
        end else if (restart_o) begin
            state_q <= KEY_IDLE;
        end else if (wr_act && (wr_data_i == KEY_OPEN)) begin
            state_q <= KEY_ARMED;
        end
    end

    assert_disabled_idle_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> state_q == KEY_IDLE);

    assert_stray_close_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && wr_data_i == KEY_CLOSE && state_q == KEY_IDLE) |=> state_q == KEY_IDLE);
endmodule

// File: rtl/wdg_timeout.sv
// Module: wdg_timeout
// Counts enabled cycles and compares the count against each selectable
// limit. It reports expiry for the limit that period_sel chooses.
// Assumes: the limit for selection g is 2^(BASE_EXP+STEP_EXP*g)-1.
module wdg_timeout #(
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned BASE_EXP = 10,
    parameter int unsigned STEP_EXP = 2,
    localparam int unsigned NUM_SEL = 2 ** SEL_W,
    localparam int unsigned CNT_W   = BASE_EXP + STEP_EXP * (NUM_SEL - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [SEL_W-1:0] period_sel_i,
    input  logic             restart_i,
    input  logic             fire_i,
    output logic             expired_o,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_SEL-1:0] hit;

    // One comparator per selectable period.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_limit
        localparam int unsigned EXP_G = BASE_EXP + STEP_EXP * g;
        localparam logic [CNT_W-1:0] LIMIT_G = CNT_W'((64'd1 << EXP_G) - 64'd1);
        assign hit[g] = (cnt_q >= LIMIT_G);
    end

    // Purpose: select the active comparator.
    always_comb begin
        expired_o = enable_i && hit[period_sel_i];
    end

    // Purpose: advance or clear the timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i || restart_i || fire_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    assert_disabled_clear_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> cnt_q == '0);

    assert_count_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !restart_i && !fire_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    assert_restart_clears_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);
endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed_watchdog
// Top of the two-key watchdog. It joins the key decoder and the timeout
// counter and registers the one-cycle reset request.
// Assumes: wr_data is valid whenever wr_en is high, and all inputs are synchronous to clk.
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned BASE_EXP = 10,
    parameter int unsigned STEP_EXP = 2,
    localparam int unsigned NUM_SEL = 2 ** SEL_W,
    localparam int unsigned CNT_W   = BASE_EXP + STEP_EXP * (NUM_SEL - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             reset_req
);
    logic             restart;
    logic             bad_key;
    logic             expired;
    logic             fire;
    logic             req_q;
    logic [CNT_W-1:0] count;

    wdg_key_seq i_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .clear_i   (fire),
        .restart_o (restart),
        .bad_key_o (bad_key)
    );

    wdg_timeout #(
        .SEL_W    (SEL_W),
        .BASE_EXP (BASE_EXP),
        .STEP_EXP (STEP_EXP)
    ) i_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable),
        .period_sel_i (period_sel),
        .restart_i    (restart),
        .fire_i       (fire),
        .expired_o    (expired),
        .count_o      (count)
    );

    // Purpose: a completion on the expiry edge wins; a bad key always fires.
    always_comb begin
        fire = bad_key || (expired && !restart);
    end

    // Purpose: register the reset request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= fire;
        end
    end

    assign reset_req = req_q;

    assert_quiet_disabled_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !reset_req);

    assert_bad_key_fires_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en && wr_data != KEY_OPEN && wr_data != KEY_CLOSE) |=> reset_req);

    assert_fire_clears_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> count == '0);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       reset_req;

    int total = 0;
    int bad = 0;

    keyed_watchdog i_keyed_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .period_sel (period_sel),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .reset_req  (reset_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input logic exp, input string req);
        total++;
        if (reset_req !== exp) begin
            bad++;
            $display("FAIL %s: reset_req=%b expected %b at %0t", req, reset_req, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic start(input logic [1:0] sel);
        enable = 1'b0;
        period_sel = sel;
        step();
        enable = 1'b1;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        enable = 1'b1;
        wr_en = 1'b1;
        wr_data = 8'h12;
        run(3);
        chk(1'b0, "R9 reset holds request low");
        wr_en = 1'b0;
        rst_n = 1'b1;
        run(1023);
        chk(1'b0, "R9 counter clear after reset");
        step();
        chk(1'b1, "R9 full period after reset");
        enable = 1'b0;
        step();
    endtask

    task automatic t_timeout(input logic [1:0] sel, input int p, input bit full);
        start(sel);
        run(p - 1);
        chk(1'b0, "R2 no request before period");
        step();
        chk(1'b1, "R2 request at period");
        if (full) begin
            step();
            chk(1'b0, "R6 single-cycle pulse");
            run(p - 2);
            chk(1'b0, "R6 counter cleared by fire");
            step();
            chk(1'b1, "R6 next request a full period later");
        end
    endtask

    task automatic t_service();
        start(2'd0);
        run(500);
        wr(8'h55);
        run(10);
        wr(8'h55);
        run(3);
        wr(8'hAA);
        run(1023);
        chk(1'b0, "R3 key pair restarts timer");
        step();
        chk(1'b1, "R3 expiry a period after completion");
    endtask

    task automatic t_stray_close();
        start(2'd0);
        run(100);
        wr(8'hAA);
        run(1024 - 1 - 101);
        chk(1'b0, "R4 before period");
        step();
        chk(1'b1, "R4 lone 0xAA ignored");
    endtask

    task automatic t_bad_key();
        start(2'd0);
        run(20);
        wr(8'h55);
        wr(8'h12);
        chk(1'b1, "R5 illegal byte fires next cycle");
        wr(8'hAA);
        chk(1'b0, "R6 pulse ends");
        run(1022);
        chk(1'b0, "R6 before period after fire");
        step();
        chk(1'b1, "R6 key state cleared by fire");
    endtask

    task automatic t_disable();
        start(2'd0);
        run(1000);
        enable = 1'b0;
        run(5);
        wr(8'h33);
        chk(1'b0, "R1 writes ignored while disabled");
        enable = 1'b1;
        run(1023);
        chk(1'b0, "R1 counter held clear while disabled");
        step();
        chk(1'b1, "R1 full period after enable");
    endtask

    task automatic t_race();
        start(2'd0);
        run(1022);
        wr(8'h55);
        wr(8'hAA);
        chk(1'b0, "R7 completion on expiry edge wins");
        run(1023);
        chk(1'b0, "R7 timer restarted");
        step();
        chk(1'b1, "R7 later expiry");
    endtask

    task automatic t_shrink();
        start(2'd1);
        run(2000);
        chk(1'b0, "R8 long period not yet reached");
        period_sel = 2'd0;
        step();
        chk(1'b1, "R8 shorter period already passed");
    endtask

    initial begin
        run(200000);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_timeout(2'd0, 1024, 1'b1);
        t_service();
        t_stray_close();
        t_bad_key();
        t_disable();
        t_race();
        t_shrink();
        t_timeout(2'd1, 4096, 1'b0);
        t_timeout(2'd2, 16384, 1'b0);
        t_timeout(2'd3, 65536, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule